// File: doc/BRIEF.md
# Delayed Selection Response Controller

This block sits on the target side of a parallel bus that uses an arbitrate-then-select handshake. It holds the target's control byte, a delay byte and an output data latch. It watches the bus for a selection aimed at its own ID. When such a selection is seen, the target answers by driving BSY. The answer can come on the next clock, or it can wait a programmed number of prescaled ticks first. While the target waits, the initiator can withdraw. If it does, the attempt is discarded and BSY is never driven.

The block also runs a selection time-out counter. Its reload value drops from a long normal count to a short one while a test bit is set. The block also produces the parity bit for the data latch when the target is in low-level mode. Three resets return it to its idle state: the power-up/pin reset, a chip-reset command and a bus reset.

States and transitions of the controller:
- IDLE to DELAY happens on a selection while delayed response is enabled and the delay byte is non-zero.
- IDLE to RESPOND happens on a selection in every other case.
- DELAY to RESPOND happens on the tick that uses up the delay.
- DELAY to ABORT happens when the initiator withdraws, that is SEL falls or BSY from another device is seen.
- RESPOND to IDLE happens on `xfer_done`.
- ABORT to IDLE happens once SEL is low.
- Any state goes to IDLE on a chip-reset command or a bus reset.

Top module: `sdr_top`

## Requirements
- R1: The control byte reads back as zero after the power-up/pin reset, after a chip-reset command and after a bus reset. Its bit 7 is reserved, always reads 0 and ignores writes. Bits 6..0 read back as written.
- R2: A selection is answered with `bsy_out` high in the cycle after detection if bit 4 (delay enable) is 0, or if the delay byte is 0.
- R3: A selection is detected only when `sel_in` is 1, `bsy_in` is 0 and `data_in[own_id]` is 1. Any other combination leaves `bsy_out` at 0.
- R4: With bit 4 set and a delay byte of D>0, the block counts `tick` pulses sampled after detection. `bsy_out` stays 0 until the D-th pulse and is 1 in the cycle after it.
- R5: During the delay, a low `sel_in` or a high `bsy_in` abandons the attempt, and `bsy_out` is not asserted for it. An abandonment that falls in the same cycle as the final delay tick still wins.
- R6: After an abandoned attempt, no new selection is accepted until `sel_in` has been seen low.
- R7: Once asserted, `bsy_out` stays high, whatever `sel_in` does, until `xfer_done`. It is 0 in the following cycle.
- R8: Each detected selection reloads the time-out counter. The reload value is 480 ticks, or 8 ticks while bit 6 is set. `sel_tmo` rises after that many ticks and stays high until the next reload.
- R9: With bit 0 (low-level mode) set, `parity_out` gives even parity over `odl_out` when bit 5 is 1 and odd parity when bit 5 is 0. With bit 0 clear, `parity_out` is 0.
- R10: A chip-reset command or a bus reset returns the controller to IDLE. It drops `bsy_out` and clears `sel_tmo` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up/pin reset, active low |
| soft_rst | input | 1 | Chip-reset command, synchronous |
| bus_rst | input | 1 | Bus reset seen, synchronous |
| cfg_we | input | 1 | Write strobe for the control byte |
| cfg_wdata | input | 8 | Control byte write data |
| dly_we | input | 1 | Write strobe for the delay byte |
| dly_wdata | input | 8 | Delay in ticks |
| odl_we | input | 1 | Write strobe for the output data latch |
| odl_wdata | input | 8 | Output data latch write data |
| own_id | input | 3 | This target's bus ID |
| sel_in | input | 1 | SEL line from the bus |
| bsy_in | input | 1 | BSY driven by other devices |
| data_in | input | 8 | Bus data lines |
| tick | input | 1 | One-cycle pulse from the prescaler |
| xfer_done | input | 1 | Target has finished with the bus |
| cfg_rdata | output | 8 | Control byte read back |
| odl_out | output | 8 | Output data latch |
| parity_out | output | 1 | Parity for the output data latch |
| bsy_out | output | 1 | Drive BSY onto the bus |
| sel_tmo | output | 1 | Selection time-out reached |

## Verification
Two events can fall in the same cycle: the tick that completes the delay and the initiator withdrawing its selection. The bench provokes this by dropping `sel_in` on the very cycle that carries the last delay tick. It then judges that `bsy_out` stays low afterwards and that the next selection starts from IDLE. A second overlap is a bus reset while the time-out is counting and BSY is driven. Here both outputs must be low one cycle later.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DELAY,
        ST_RESPOND,
        ST_ABORT
    } sdr_state_e;

    localparam int CFG_LOWLVL   = 0;
    localparam int CFG_DLY_EN   = 4;
    localparam int CFG_PAR_EVEN = 5;
    localparam int CFG_TMO_TEST = 6;
    localparam int CFG_RSVD     = 7;
endpackage

// File: rtl/sdr_regs.sv
module sdr_regs #(
    parameter int DATA_W = 8,
    parameter int DLY_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_clr,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              dly_we,
    input  logic [DLY_W-1:0]  dly_wdata,
    input  logic              odl_we,
    input  logic [DATA_W-1:0] odl_wdata,
    output logic [DATA_W-1:0] cfg_q,
    output logic [DLY_W-1:0]  dly_q,
    output logic [DATA_W-1:0] odl_q
);
    import sdr_pkg::*;

    localparam logic [DATA_W-1:0] WR_MASK = ~(DATA_W'(1) << CFG_RSVD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (sync_clr) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= cfg_wdata & WR_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q <= '0;
            odl_q <= '0;
        end else begin
            if (dly_we) dly_q <= dly_wdata;
            if (odl_we) odl_q <= odl_wdata;
        end
    end

    AST_CFG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clr |=> (cfg_q == '0)); // R1
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !cfg_q[CFG_RSVD]); // R1
endmodule

// File: rtl/sdr_timeout.sv
module sdr_timeout #(
    parameter int TMO_NORMAL = 480,
    parameter int TMO_TEST   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_clr,
    input  logic load,
    input  logic test,
    input  logic tick,
    output logic tmo
);
    localparam int TMO_W = $clog2(TMO_NORMAL + 1);

    logic [TMO_W-1:0] cnt;
    logic             armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (sync_clr) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (load) begin
            cnt   <= test ? TMO_W'(TMO_TEST) : TMO_W'(TMO_NORMAL);
            armed <= 1'b1;
        end else if (armed && tick && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign tmo = armed && (cnt == '0);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && !load && !sync_clr) |=> tmo); // R8
    AST_RELOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !sync_clr) |=> !tmo); // R8
endmodule

// File: rtl/sdr_parity.sv
module sdr_parity #(
    parameter int DATA_W = 8
) (
    input  logic              lowlvl,
    input  logic              even_sel,
    input  logic [DATA_W-1:0] data,
    output logic              par
);
    always_comb begin
        if (!lowlvl) par = 1'b0;
        else if (even_sel) par = ^data;
        else par = ~^data;
    end
endmodule

// File: rtl/sdr_top.sv
module sdr_top #(
    parameter int DATA_W     = 8,
    parameter int DLY_W      = 8,
    parameter int ID_W       = $clog2(DATA_W),
    parameter int TMO_NORMAL = 480,
    parameter int TMO_TEST   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              bus_rst,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              dly_we,
    input  logic [DLY_W-1:0]  dly_wdata,
    input  logic              odl_we,
    input  logic [DATA_W-1:0] odl_wdata,
    input  logic [ID_W-1:0]   own_id,
    input  logic              sel_in,
    input  logic              bsy_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              tick,
    input  logic              xfer_done,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic [DATA_W-1:0] odl_out,
    output logic              parity_out,
    output logic              bsy_out,
    output logic              sel_tmo
);
    import sdr_pkg::*;

    sdr_state_e        state, nxt;
    logic              sync_clr;
    logic              sel_det;
    logic              hold_off;
    logic              withdraw;
    logic [DATA_W-1:0] cfg_q;
    logic [DLY_W-1:0]  dly_q;
    logic [DLY_W-1:0]  dly_cnt;

    assign sync_clr = soft_rst | bus_rst;

    sdr_regs #(.DATA_W(DATA_W), .DLY_W(DLY_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .dly_we(dly_we), .dly_wdata(dly_wdata),
        .odl_we(odl_we), .odl_wdata(odl_wdata),
        .cfg_q(cfg_q), .dly_q(dly_q), .odl_q(odl_out)
    );

    sdr_timeout #(.TMO_NORMAL(TMO_NORMAL), .TMO_TEST(TMO_TEST)) i_tmo (
        .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr),
        .load((state == ST_IDLE) && sel_det),
        .test(cfg_q[CFG_TMO_TEST]), .tick(tick), .tmo(sel_tmo)
    );

    sdr_parity #(.DATA_W(DATA_W)) i_par (
        .lowlvl(cfg_q[CFG_LOWLVL]), .even_sel(cfg_q[CFG_PAR_EVEN]),
        .data(odl_out), .par(parity_out)
    );

    assign sel_det  = sel_in && !bsy_in && data_in[own_id];
    assign hold_off = cfg_q[CFG_DLY_EN] && (dly_q != '0);
    assign withdraw = !sel_in || bsy_in;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (sel_det) nxt = hold_off ? ST_DELAY : ST_RESPOND;
            ST_DELAY:   if (withdraw) nxt = ST_ABORT;
                        else if (tick && (dly_cnt == DLY_W'(1))) nxt = ST_RESPOND;
            ST_RESPOND: if (xfer_done) nxt = ST_IDLE;
            ST_ABORT:   if (!sel_in) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else if (sync_clr) state <= ST_IDLE;
        else state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly_cnt <= '0;
        else if ((state == ST_IDLE) && sel_det) dly_cnt <= dly_q;
        else if ((state == ST_DELAY) && tick && (dly_cnt != '0)) dly_cnt <= dly_cnt - 1'b1;
    end

    always_comb begin
        bsy_out   = (state == ST_RESPOND);
        cfg_rdata = cfg_q;
    end

    AST_IMMEDIATE_REPLY: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
        ((state == ST_IDLE) && sel_det && !hold_off) |=> bsy_out); // R2
    AST_NO_DETECT: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
        ((state == ST_IDLE) && !sel_in) |=> !bsy_out); // R3
    AST_WITHDRAW_WINS: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
        ((state == ST_DELAY) && withdraw) |=> (state == ST_ABORT)); // R5
    AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
        ((state == ST_ABORT) && sel_in) |=> (state == ST_ABORT)); // R6
    AST_BSY_KEPT: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
        (bsy_out && !xfer_done) |=> bsy_out); // R7
    AST_RESET_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clr |=> (!bsy_out && !sel_tmo)); // R10
    AST_PAR_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[CFG_LOWLVL] && cfg_q[CFG_PAR_EVEN]) |-> (^{odl_out, parity_out} == 1'b0)); // R9
endmodule

// File: tb/test_sdr_top.sv
`timescale 1ns/100ps
module test_sdr_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0, bus_rst = 1'b0;
    logic       cfg_we = 1'b0, dly_we = 1'b0, odl_we = 1'b0;
    logic [7:0] cfg_wdata = '0, dly_wdata = '0, odl_wdata = '0;
    logic [2:0] own_id = 3'd5;
    logic       sel_in = 1'b0, bsy_in = 1'b0, tick = 1'b0, xfer_done = 1'b0;
    logic [7:0] data_in = '0;
    logic [7:0] cfg_rdata, odl_out;
    logic       parity_out, bsy_out, sel_tmo;
    int         n_chk = 0, n_err = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    sdr_top i_sdr_top (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bus_rst(bus_rst),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .dly_we(dly_we), .dly_wdata(dly_wdata),
        .odl_we(odl_we), .odl_wdata(odl_wdata), .own_id(own_id), .sel_in(sel_in),
        .bsy_in(bsy_in), .data_in(data_in), .tick(tick), .xfer_done(xfer_done),
        .cfg_rdata(cfg_rdata), .odl_out(odl_out), .parity_out(parity_out),
        .bsy_out(bsy_out), .sel_tmo(sel_tmo)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v; cyc(1); cfg_we = 1'b0;
    endtask

    task automatic wr_dly(input logic [7:0] v);
        dly_we = 1'b1; dly_wdata = v; cyc(1); dly_we = 1'b0;
    endtask

    task automatic pulse_tick;
        tick = 1'b1; cyc(1); tick = 1'b0;
    endtask

    task automatic start_sel;
        sel_in = 1'b1; data_in = 8'h01 << own_id; cyc(1);
    endtask

    task automatic finish_sel;
        sel_in = 1'b0; data_in = '0;
        xfer_done = 1'b1; cyc(1); xfer_done = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        check("R1 reset cfg", cfg_rdata, 8'h00);
        check("R10 reset bsy", bsy_out, 1'b0);
        check("R8 reset tmo", sel_tmo, 1'b0);

        // R1: reserved bit and the three clear sources
        wr_cfg(8'hFF); check("R1 rsvd bit", cfg_rdata, 8'h7F);
        wr_cfg(8'h0E); check("R1 readback", cfg_rdata, 8'h0E);
        soft_rst = 1'b1; cyc(1); soft_rst = 1'b0; check("R1 chip reset", cfg_rdata, 8'h00);
        wr_cfg(8'h7F); bus_rst = 1'b1; cyc(1); bus_rst = 1'b0; check("R1 bus reset", cfg_rdata, 8'h00);
        wr_cfg(8'h7F); rst_n = 1'b0; cyc(1); rst_n = 1'b1; check("R1 pin reset", cfg_rdata, 8'h00);

        // R3: non-matching conditions
        sel_in = 1'b1; data_in = ~(8'h01 << own_id); cyc(3);
        check("R3 wrong id", bsy_out, 1'b0);
        data_in = 8'h01 << own_id; bsy_in = 1'b1; cyc(3);
        check("R3 bsy busy", bsy_out, 1'b0);
        sel_in = 1'b0; bsy_in = 1'b0; cyc(3);
        check("R3 no sel", bsy_out, 1'b0);
        data_in = '0;

        // R2 + R7: every ID, delay disabled
        for (int id = 0; id < 8; id++) begin
            own_id = 3'(id);
            start_sel;
            check("R2 immediate bsy", bsy_out, 1'b1);
            sel_in = 1'b0; cyc(3);
            check("R7 bsy held", bsy_out, 1'b1);
            finish_sel;
            check("R7 bsy released", bsy_out, 1'b0);
        end
        own_id = 3'd5;

        // R2: delay enabled but delay byte zero
        wr_dly(8'd0); wr_cfg(8'h10);
        start_sel; check("R2 zero delay", bsy_out, 1'b1); finish_sel;

        // R4: delay sweep
        for (int d = 1; d <= 6; d++) begin
            wr_dly(8'(d));
            start_sel;
            for (int k = 1; k <= d; k++) begin
                check("R4 waiting", bsy_out, 1'b0);
                pulse_tick;
                if (k < d) begin
                    cyc(1);
                end
            end
            check("R4 after delay", bsy_out, 1'b1);
            finish_sel;
        end

        // R5: withdraw in the same cycle as the last delay tick
        wr_dly(8'd2);
        start_sel; pulse_tick;
        sel_in = 1'b0; tick = 1'b1; cyc(1); tick = 1'b0;
        check("R5 collision", bsy_out, 1'b0);
        cyc(2); check("R5 stays low", bsy_out, 1'b0);
        start_sel; pulse_tick; pulse_tick;
        check("R5 fresh attempt", bsy_out, 1'b1);
        finish_sel;

        // R6: abort by foreign BSY, then held until SEL falls
        wr_dly(8'd3);
        start_sel; pulse_tick;
        bsy_in = 1'b1; cyc(1); bsy_in = 1'b0;
        for (int k = 0; k < 4; k++) begin
            pulse_tick;
            check("R6 abort held", bsy_out, 1'b0);
        end
        wr_cfg(8'h00);
        sel_in = 1'b0; cyc(1);
        start_sel; check("R6 reselect", bsy_out, 1'b1);
        finish_sel;

        // R8: short and normal time-out
        wr_cfg(8'h40);
        start_sel; sel_in = 1'b0;
        check("R8 start", sel_tmo, 1'b0);
        for (int k = 1; k <= 10; k++) begin
            pulse_tick;
            check("R8 test count", sel_tmo, (k >= 8) ? 1'b1 : 1'b0);
        end
        finish_sel;
        wr_cfg(8'h00);
        start_sel; sel_in = 1'b0;
        check("R8 reloaded", sel_tmo, 1'b0);
        for (int k = 1; k <= 481; k++) begin
            pulse_tick;
            if (k >= 478) check("R8 normal count", sel_tmo, (k >= 480) ? 1'b1 : 1'b0);
        end

        // R10: bus reset while driving BSY with time-out reached
        check("R10 pre", bsy_out, 1'b1);
        bus_rst = 1'b1; cyc(1); bus_rst = 1'b0;
        check("R10 bsy dropped", bsy_out, 1'b0);
        check("R10 tmo cleared", sel_tmo, 1'b0);
        wr_cfg(8'h10); wr_dly(8'd2);
        start_sel;
        soft_rst = 1'b1; cyc(1); soft_rst = 1'b0;
        sel_in = 1'b0; data_in = '0;
        pulse_tick; pulse_tick; pulse_tick;
        check("R10 delay cancelled", bsy_out, 1'b0);

        // R9: parity sweep
        for (int m = 0; m < 3; m++) begin
            wr_cfg((m == 0) ? 8'h21 : (m == 1) ? 8'h01 : 8'h20);
            for (int v = 0; v < 256; v++) begin
                logic exp_p;
                odl_we = 1'b1; odl_wdata = 8'(v); cyc(1); odl_we = 1'b0;
                exp_p = (m == 2) ? 1'b0 : (m == 0) ? ^8'(v) : ~^8'(v);
                check("R9 parity", parity_out, exp_p);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule